// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This block connects a processor's register datapath to a small memory in which every address names one 8-bit location. Each request carries an operation (byte load, byte store, word load, word store), a 32-bit base value taken from a register, a 16-bit signed displacement and 32-bit store data. The unit adds the sign-extended displacement to the base to form the effective address, then reads or writes the memory array.

Word accesses move four consecutive bytes, with the most significant byte at the lowest address. They are legal only on addresses that are multiples of four. A word access at any other address raises an error flag and is not carried out. Byte loads come back sign-extended to 32 bits. Byte stores write only the low 8 bits of the store data. Every request is answered by a one-cycle response strobe in the following cycle.

Top module: `lsu_core`

## Requirements
- R1: The effective address is base plus the 16-bit displacement sign-extended to 32 bits, taken modulo the memory depth (default 1024 bytes). A negative displacement and a sum that wraps past the top of the array both reach the expected byte, and displacement 8 from a word array base reaches its third word.
- R2: A byte load (op code 2'b00) returns the addressed byte in bits 7:0 with bit 7 copied into bits 31:8, so 0x08 reads as 0x00000008 and 0x80 reads as 0xFFFFFF80.
- R3: A byte store (op code 2'b01) writes bits 7:0 of the store data to the addressed location only, and leaves the other three bytes of the same word unchanged.
- R4: A word store (op code 2'b11) places store bits 31:24 at address A, 23:16 at A+1, 15:8 at A+2 and 7:0 at A+3. A word load (op code 2'b10) reassembles the same order.
- R5: A word access whose effective address has bits 1:0 not equal to 00 responds with bus_err high and load_data zero. When the access is a store it changes no memory byte.
- R6: Byte accesses at any address, including those with bits 1:0 not equal to 00, never raise bus_err.
- R7: rsp_valid is high in exactly the cycle after a cycle with req_valid high and low otherwise. load_data is zero for stores and in idle cycles, and bus_err is low in idle cycles.
- R8: While rst_n is low, rsp_valid, bus_err and load_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 byte load, 01 byte store, 10 word load, 11 word store |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Data for stores |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| load_data | output | 32 | Load result |
| bus_err | output | 1 | Misaligned word access flag |

## Verification
The hardest case to reach is the one R5 covers for stores: a rejected word store leaves no trace on the outputs when it is issued, so the only proof that memory stayed intact comes from later loads. The stimulus first fills the whole array with known word patterns. It then issues misaligned word stores with a distinctive value over those patterns and reads back every byte of the surrounding words. The behavioural reference model predicts the untouched contents, and the bench compares against it on every clock. Address wrap is reached with a base near the top of the 32-bit range and with positive displacements past the end of the array.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    LSU_LDB = 2'b00,
    LSU_STB = 2'b01,
    LSU_LDW = 2'b10,
    LSU_STW = 2'b11
  } lsu_op_e;

  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;

  typedef logic [LANES-1:0][BYTE_W-1:0] lane_vec_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [31:0]       base_val,
  input  logic [15:0]       disp,
  input  logic [31:0]       store_data,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              is_word,
  output logic              is_load,
  output logic              misalign,
  output logic [LANES-1:0]  lane_we,
  output lane_vec_t         lane_wdata
);
  logic [31:0] sum_full;
  logic        unused_hi;
  lsu_op_e     op;

  always_comb begin
    op        = lsu_op_e'(req_op);
    sum_full  = base_val + {{16{disp[15]}}, disp};
    eff_addr  = sum_full[ADDR_W-1:0];
    is_word   = op[1];
    is_load   = !op[0];
    misalign  = is_word && (sum_full[1:0] != 2'b00);
    lane_we   = '0;
    for (int k = 0; k < LANES; k++) begin
      // lane 0 holds the byte at the lowest address, so the MSB goes there
      lane_wdata[k] = is_word ? store_data[WORD_W-1-k*BYTE_W -: BYTE_W]
                              : store_data[BYTE_W-1:0];
    end
    if (req_valid && (op == LSU_STW) && !misalign) begin
      lane_we = '1;
    end else if (req_valid && (op == LSU_STB)) begin
      lane_we[sum_full[1:0]] = 1'b1;
    end
  end

  assign unused_hi = ^sum_full[31:ADDR_W];

  always_comb begin
    AST_MISALIGNED_BLOCKS_WRITE: assert (!(misalign && (lane_we != '0))); // R5
    AST_LANE_PATTERN: assert ((lane_we == '0) || (lane_we == '1)
                              || ($countones(lane_we) == 1));            // R3
  end
endmodule

// File: rtl/lsu_byte_mem.sv
module lsu_byte_mem
  import lsu_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024,
  localparam int unsigned WORDS  = MEM_BYTES / LANES,
  localparam int unsigned WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [WIDX_W-1:0] word_idx,
  input  logic [LANES-1:0]  lane_we,
  input  lane_vec_t         lane_wdata,
  output lane_vec_t         lane_rdata
);
  lane_vec_t mem_q [WORDS];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_we[k]) begin
        mem_q[word_idx][k] <= lane_wdata[k];
      end
    end
  end

  assign lane_rdata = mem_q[word_idx];

  initial begin
    AST_DEPTH_WORD_MULTIPLE: assert ((MEM_BYTES % LANES) == 0 && WORDS >= 2); // R1
  end
endmodule

// File: rtl/lsu_result_fmt.sv
module lsu_result_fmt
  import lsu_pkg::*;
(
  input  logic        is_word,
  input  logic [1:0]  lane_sel,
  input  lane_vec_t   lane_rdata,
  output logic [31:0] result
);
  logic [BYTE_W-1:0] pick;

  always_comb begin
    pick = lane_rdata[lane_sel];
    if (is_word) begin
      for (int k = 0; k < LANES; k++) begin
        result[WORD_W-1-k*BYTE_W -: BYTE_W] = lane_rdata[k];
      end
    end else begin
      result = {{(WORD_W-BYTE_W){pick[BYTE_W-1]}}, pick};
    end
  end

  always_comb begin
    AST_BYTE_SIGN_FILL: assert (is_word || (result[31:8] == {24{pick[7]}})); // R2
  end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024,
  localparam int unsigned ADDR_W = $clog2(MEM_BYTES),
  localparam int unsigned WIDX_W = ADDR_W - 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [31:0] base_val,
  input  logic [15:0] disp,
  input  logic [31:0] store_data,
  output logic        rsp_valid,
  output logic [31:0] load_data,
  output logic        bus_err
);
  logic [ADDR_W-1:0] eff_addr;
  logic              is_word, is_load, misalign;
  logic [LANES-1:0]  lane_we;
  lane_vec_t         lane_wdata, lane_rdata;
  logic [31:0]       fmt_result;

  logic        valid_d, valid_q;
  logic [31:0] data_d, data_q;
  logic        err_d, err_q;

  lsu_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .req_valid  (req_valid),
    .req_op     (req_op),
    .base_val   (base_val),
    .disp       (disp),
    .store_data (store_data),
    .eff_addr   (eff_addr),
    .is_word    (is_word),
    .is_load    (is_load),
    .misalign   (misalign),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata)
  );

  lsu_byte_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk        (clk),
    .word_idx   (eff_addr[ADDR_W-1:2]),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata),
    .lane_rdata (lane_rdata)
  );

  lsu_result_fmt u_fmt (
    .is_word    (is_word),
    .lane_sel   (eff_addr[1:0]),
    .lane_rdata (lane_rdata),
    .result     (fmt_result)
  );

  // next-state
  always_comb begin
    valid_d = req_valid;
    err_d   = req_valid && misalign;
    data_d  = (req_valid && is_load && !misalign) ? fmt_result : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      err_q   <= err_d;
    end
  end

  assign rsp_valid = valid_q;
  assign load_data = data_q;
  assign bus_err   = err_q;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !bus_err && load_data == '0)); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (rsp_valid && load_data == '0)); // R5
  AST_BYTE_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_op[1]) |=> !bus_err); // R6
  AST_STORE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[0]) |=> (load_data == '0)); // R7
  AST_BYTE_LOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00) |=>
      (load_data[31:8] == '0 || load_data[31:8] == '1)); // R2
endmodule

// File: tb/lsu_core_bench.sv
`timescale 1ns/1ps
module lsu_core_bench;
  localparam int MEM = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] base_val = '0;
  logic [15:0] disp = '0;
  logic [31:0] store_data = '0;
  logic        rsp_valid;
  logic [31:0] load_data;
  logic        bus_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit armed = 0;
  string cur_tag = "R8";

  // reference model state
  logic [7:0]  mdl [MEM];
  logic        exp_valid = 0;
  logic [31:0] exp_data = '0;
  logic        exp_err = 0;
  string       exp_tag = "R8";

  always #2.5 clk = ~clk;

  lsu_core #(.MEM_BYTES(MEM)) u_lsu_core (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base_val(base_val), .disp(disp), .store_data(store_data),
    .rsp_valid(rsp_valid), .load_data(load_data), .bus_err(bus_err)
  );

  initial for (int i = 0; i < MEM; i++) mdl[i] = 8'h00;

  // behavioural reference: compute what the outputs should be after this edge
  always @(posedge clk) begin
    int ea;
    logic [31:0] sum;
    armed = 1;
    exp_tag = cur_tag;
    exp_valid = 0; exp_data = '0; exp_err = 0;
    if (rst_n && req_valid) begin
      sum = base_val + {{16{disp[15]}}, disp};
      ea  = int'(sum % MEM);
      exp_valid = 1;
      if (req_op[1] && (ea % 4 != 0)) begin
        exp_err = 1;
      end else begin
        case (req_op)
          2'b00: exp_data = {{24{mdl[ea][7]}}, mdl[ea]};
          2'b01: mdl[ea] = store_data[7:0];
          2'b10: exp_data = {mdl[ea], mdl[ea+1], mdl[ea+2], mdl[ea+3]};
          default: begin
            mdl[ea]   = store_data[31:24];
            mdl[ea+1] = store_data[23:16];
            mdl[ea+2] = store_data[15:8];
            mdl[ea+3] = store_data[7:0];
          end
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (rsp_valid !== exp_valid || load_data !== exp_data || bus_err !== exp_err) begin
        failures++;
        $display("FAIL %s: got valid=%0b data=%08h err=%0b expected valid=%0b data=%08h err=%0b",
                 exp_tag, rsp_valid, load_data, bus_err, exp_valid, exp_data, exp_err);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] d, input string tag);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1'b1; req_op = op; base_val = b; disp = o; store_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag = "R7";
      req_valid = 1'b0; req_op = 2'b00; base_val = '0; disp = '0; store_data = '0;
    end
  endtask

  initial begin
    // R8: outputs held at zero while reset is low
    cur_tag = "R8";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R4: fill every word with a known big-endian pattern
    for (int i = 0; i < MEM/4; i++) begin
      logic [7:0] b8 = 8'(i);
      issue(2'b11, 32'(i*4), 16'h0, {b8, ~b8, b8 ^ 8'h5A, b8 | 8'h80}, "R4");
    end
    idle(1);

    // R3 and R2: byte stores into one word, then sign-extended byte loads
    issue(2'b01, 32'd100, 16'h0, 32'hFFFF_FF08, "R3");
    issue(2'b01, 32'd101, 16'h0, 32'h1234_5680, "R3");
    issue(2'b00, 32'd100, 16'h0, 32'h0, "R2");   // expect 0x00000008
    issue(2'b00, 32'd101, 16'h0, 32'h0, "R2");   // expect 0xFFFFFF80
    issue(2'b10, 32'd100, 16'h0, 32'h0, "R3");   // neighbours 102,103 intact
    idle(1);

    // R4: store then read back word, back to back
    issue(2'b11, 32'd200, 16'h0, 32'hA1B2_C3D4, "R4");
    issue(2'b10, 32'd200, 16'h0, 32'h0, "R4");
    issue(2'b00, 32'd200, 16'h0, 32'h0, "R4");   // MSB at lowest address
    issue(2'b00, 32'd203, 16'h0, 32'h0, "R4");

    // R1: negative displacement, array stride, wrap
    issue(2'b10, 32'd200, 16'hFFFC, 32'h0, "R1");
    issue(2'b10, 32'd976, 16'd8, 32'h0, "R1");
    issue(2'b10, 32'hFFFF_FFFC, 16'h0, 32'h0, "R1");
    issue(2'b11, 32'd1020, 16'd8, 32'h0BAD_F00D, "R1");
    issue(2'b10, 32'd4, 16'h0, 32'h0, "R1");
    issue(2'b00, 32'h0000_0400, 16'h8001, 32'h0, "R1");
    idle(2);

    // R5: misaligned word stores leave memory untouched, loads return zero
    issue(2'b11, 32'd301, 16'h0, 32'hDEAD_BEEF, "R5");
    issue(2'b11, 32'd298, 16'h0, 32'hDEAD_BEEF, "R5");
    issue(2'b11, 32'd300, 16'h3, 32'hDEAD_BEEF, "R5");
    issue(2'b10, 32'd300, 16'h0, 32'h0, "R5");
    issue(2'b10, 32'd296, 16'h0, 32'h0, "R5");
    issue(2'b10, 32'd304, 16'h0, 32'h0, "R5");
    issue(2'b10, 32'd402, 16'h0, 32'h0, "R5");
    issue(2'b10, 32'd400, 16'hFFFF, 32'h0, "R5");
    idle(1);

    // R6: byte accesses at every alignment never flag an error
    for (int k = 0; k < 4; k++) begin
      issue(2'b01, 32'(500 + k), 16'h0, 32'(8'h7C + k*8'h21), "R6");
      issue(2'b00, 32'(500 + k), 16'h0, 32'h0, "R6");
    end
    issue(2'b10, 32'd500, 16'h0, 32'h0, "R6");
    idle(3);

    // R8: reset in mid-run clears the outputs
    issue(2'b10, 32'd100, 16'h0, 32'h0, "R8");
    @(negedge clk);
    req_valid = 1'b0;
    cur_tag = "R8";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end
endmodule